// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This unit turns the per-sector partial remainders of a binary BCH code over GF(2^13) into the complete set of 2t syndromes that a key-equation solver needs. An external checker leaves one 13-bit remainder polynomial per odd syndrome in a small word store. After a start strobe the unit reads those remainders itself and evaluates each one at the matching odd power of alpha. It then derives every even syndrome by squaring the syndrome at half its index.

All field arithmetic is done in logic: a 13x13 GF multiplier reduced by a primitive polynomial given as a parameter, with no log/antilog ROM. Each odd syndrome is evaluated by Horner's rule over 13 cycles, one remainder bit per cycle. Each even syndrome then takes one squaring cycle. The run ends with a one-cycle done pulse, and the results stay on the output until the next accepted start.

Top module: `bch_syn_expand`

## Requirements
- R1: While reset is held and after its release, `done` and `busy` are low and every syndrome output is zero.
- R2: Remainder index i is read from word address floor(i/2). Bits 12:0 of the word carry the even index and bits 28:16 the odd index. Bits 15:13 and 31:29 are ignored. `rem_addr` never leaves the range 0 to TMAX/2-1.
- R3: For remainder index i (0 <= i < t), the syndrome S(2i+1) is the XOR of alpha^(((2i+1)*b) mod 8191) over every set bit b of that remainder. Alpha is the root of x^13+x^4+x^3+x+1.
- R4: For j = 1..t, the syndrome S(2j) equals S(j) squared in the field, so a zero S(j) gives a zero S(2j).
- R5: `cap_sel` selects t: code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 12, and codes 4 to 7 give 24.
- R6: All syndromes are cleared when a start is accepted. Syndromes above index 2t therefore read zero after a run, whatever an earlier run left.
- R7: `done` is high for exactly one cycle, 14*t clock edges after the edge that accepts start. `busy` is high from the accepting edge through the done cycle. The outputs hold their values while idle.
- R8: A start raised while `busy` is high is ignored: the run keeps its timing and its result.
- R9: S(k) appears on `syn_o[13*(k-1) +: 13]` for k = 1..48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| cap_sel | input | 3 | Correction capability code |
| rem_addr | output | 4 | Word address into the remainder store |
| rem_word | input | 32 | Remainder word at `rem_addr`, same cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when all syndromes are valid |
| syn_o | output | 624 | 48 syndromes, 13 bits each, S(1) in the low bits |

## Verification
The assertions assume that the remainder store answers combinationally and holds its content for the whole run. They also assume that reset is applied before the first start. The bench models the store as an array indexed by `rem_addr` and never writes it while `busy` is high. Starts are raised only at falling edges; the one start pushed into a busy run tests that it is ignored. The random words include set bits in the ignored fields, so the check against the reference model also shows those bits have no effect.

// File: rtl/bchsx_pkg.sv
package bchsx_pkg;
  parameter int SX_M = 13;
  typedef logic [SX_M-1:0] gf_t;

  typedef enum logic [1:0] {SX_IDLE, SX_ODD, SX_EVEN, SX_FIN} sx_state_e;

  // multiply by alpha, reduced by the low bits of the primitive polynomial
  function automatic gf_t gf_xtime(gf_t x, gf_t poly);
    return {x[SX_M-2:0], 1'b0} ^ (x[SX_M-1] ? poly : '0);
  endfunction

  // shift-and-add field product, MSB of b first
  function automatic gf_t gf_mul(gf_t a, gf_t b, gf_t poly);
    gf_t p;
    p = '0;
    for (int k = SX_M - 1; k >= 0; k--) begin
      p = gf_xtime(p, poly);
      if (b[k]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [4:0] cap_decode(logic [2:0] code);
    case (code)
      3'd0:    return 5'd2;
      3'd1:    return 5'd4;
      3'd2:    return 5'd8;
      3'd3:    return 5'd12;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/bchsx_seq.sv
module bchsx_seq
  import bchsx_pkg::*;
#(
  parameter int TMAX = 24,
  parameter int CW   = $clog2(TMAX + 1),
  parameter int BW   = $clog2(SX_M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cap_sel,
  output logic          busy,
  output logic          done,
  output logic          accept,
  output logic          odd_step,
  output logic          odd_last,
  output logic [CW-1:0] idx,
  output logic [BW-1:0] bit_sel,
  output logic          even_step,
  output logic [CW-1:0] jdx
);
  sx_state_e     state_q, state_d;
  logic [CW-1:0] t_q, t_new;
  logic [CW-1:0] idx_q, idx_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [CW-1:0] j_q, j_d;
  logic [4:0]    t_dec;

  assign t_dec = cap_decode(cap_sel);
  assign t_new = (int'(t_dec) > TMAX) ? CW'(TMAX) : CW'(t_dec);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    bit_d   = bit_q;
    j_d     = j_q;
    accept  = 1'b0;
    case (state_q)
      SX_IDLE: if (start) begin
        accept  = 1'b1;
        state_d = SX_ODD;
        idx_d   = '0;
        bit_d   = BW'(SX_M - 1);
      end
      SX_ODD: begin
        if (bit_q == '0) begin
          bit_d = BW'(SX_M - 1);
          if (idx_q == t_q - 1'b1) begin
            state_d = SX_EVEN;
            j_d     = CW'(1);
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else begin
          bit_d = bit_q - 1'b1;
        end
      end
      SX_EVEN: begin
        if (j_q == t_q) state_d = SX_FIN;
        else            j_d     = j_q + 1'b1;
      end
      default: state_d = SX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SX_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
      j_q     <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      j_q     <= j_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      t_q <= '0;
    else if (accept) t_q <= t_new;
  end

  assign busy      = (state_q != SX_IDLE);
  assign done      = (state_q == SX_FIN);
  assign odd_step  = (state_q == SX_ODD);
  assign odd_last  = odd_step && (bit_q == '0);
  assign even_step = (state_q == SX_EVEN);
  assign idx       = idx_q;
  assign bit_sel   = bit_q;
  assign jdx       = j_q;
endmodule

// File: rtl/bchsx_eval.sv
module bchsx_eval
  import bchsx_pkg::*;
#(
  parameter gf_t POLY = 13'h001B,
  parameter int  BW   = $clog2(SX_M)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          last,
  input  logic          half_sel,
  input  logic [BW-1:0] bit_sel,
  input  logic [31:0]   rem_word,
  output gf_t           result
);
  gf_t  acc_q, beta_q, acc_d, beta_d, half;
  logic rbit;
  logic unused_rem;

  assign unused_rem = ^{rem_word[31:29], rem_word[15:13]};
  assign half   = half_sel ? rem_word[16 +: SX_M] : rem_word[0 +: SX_M];
  assign rbit   = half[bit_sel];
  // one Horner step: acc * alpha^(2i+1) + r_b
  assign acc_d  = gf_mul(acc_q, beta_q, POLY) ^ gf_t'(rbit);
  assign beta_d = gf_xtime(gf_xtime(beta_q, POLY), POLY);
  assign result = acc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      beta_q <= gf_t'(2);
    end else if (clr) begin
      acc_q  <= '0;
      beta_q <= gf_t'(2);
    end else if (step) begin
      if (last) begin
        acc_q  <= '0;
        beta_q <= beta_d;
      end else begin
        acc_q  <= acc_d;
      end
    end
  end
endmodule

// File: rtl/bchsx_bank.sv
module bchsx_bank
  import bchsx_pkg::*;
#(
  parameter int  TMAX = 24,
  parameter gf_t POLY = 13'h001B,
  parameter int  CW   = $clog2(TMAX + 1),
  parameter int  NSYN = 2 * TMAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 odd_wr,
  input  logic [CW-1:0]        odd_idx,
  input  gf_t                  odd_val,
  input  logic                 even_wr,
  input  logic [CW-1:0]        jdx,
  output logic [NSYN*SX_M-1:0] syn_flat
);
  gf_t syn_q [NSYN];
  gf_t sq_src, sq_val;
  logic [CW-1:0] src_idx;

  assign src_idx = jdx - 1'b1;
  assign sq_src  = syn_q[src_idx];
  assign sq_val  = gf_mul(sq_src, sq_src, POLY);

  for (genvar g = 0; g < NSYN; g++) begin : g_ent
    logic we;
    gf_t  wd;
    if (g % 2 == 0) begin : g_odd
      assign we = odd_wr && (int'(odd_idx) == g / 2);
      assign wd = odd_val;
    end else begin : g_even
      assign we = even_wr && (int'(jdx) == (g + 1) / 2);
      assign wd = sq_val;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   syn_q[g] <= '0;
      else if (clr) syn_q[g] <= '0;
      else if (we)  syn_q[g] <= wd;
    end
    assign syn_flat[g*SX_M +: SX_M] = syn_q[g];
  end
endmodule

// File: rtl/bch_syn_expand.sv
module bch_syn_expand
  import bchsx_pkg::*;
#(
  parameter int  TMAX = 24,
  parameter gf_t POLY = 13'h001B,
  localparam int CW   = $clog2(TMAX + 1),
  localparam int AW   = CW - 1,
  localparam int BW   = $clog2(SX_M),
  localparam int NSYN = 2 * TMAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           cap_sel,
  output logic [AW-1:0]        rem_addr,
  input  logic [31:0]          rem_word,
  output logic                 busy,
  output logic                 done,
  output logic [NSYN*SX_M-1:0] syn_o
);
  logic          accept, odd_step, odd_last, even_step;
  logic [CW-1:0] idx, jdx;
  logic [BW-1:0] bit_sel;
  gf_t           odd_val;

  bchsx_seq #(.TMAX(TMAX), .CW(CW), .BW(BW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_sel(cap_sel),
    .busy(busy), .done(done), .accept(accept), .odd_step(odd_step),
    .odd_last(odd_last), .idx(idx), .bit_sel(bit_sel),
    .even_step(even_step), .jdx(jdx)
  );

  assign rem_addr = idx[CW-1:1];

  bchsx_eval #(.POLY(POLY), .BW(BW)) eval_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(odd_step),
    .last(odd_last), .half_sel(idx[0]), .bit_sel(bit_sel),
    .rem_word(rem_word), .result(odd_val)
  );

  bchsx_bank #(.TMAX(TMAX), .POLY(POLY), .CW(CW), .NSYN(NSYN)) bank_i (
    .clk(clk), .rst_n(rst_n), .clr(accept), .odd_wr(odd_last),
    .odd_idx(idx), .odd_val(odd_val), .even_wr(even_step), .jdx(jdx),
    .syn_flat(syn_o)
  );
endmodule

// File: rtl/bch_syn_expand_chk.sv
module bch_syn_expand_chk #(
  parameter int SW   = 624,
  parameter int AW   = 4,
  parameter int HALF = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] rem_addr,
  input logic          busy,
  input logic          done,
  input logic [SW-1:0] syn_o
);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(syn_o));
  assert_clear_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (syn_o == '0));
  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(rem_addr) < HALF));
  assert_no_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

bind bch_syn_expand bch_syn_expand_chk #(.SW(NSYN*bchsx_pkg::SX_M), .AW(AW), .HALF(TMAX/2)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .rem_addr(rem_addr),
  .busy(busy), .done(done), .syn_o(syn_o)
);

// File: tb/bch_syn_expand_tb_top.sv
module bch_syn_expand_tb_top;
  localparam logic [13:0] POLYF = 14'h201B;

  logic         clk, rst_n, start, busy, done;
  logic [2:0]   cap_sel;
  logic [3:0]   rem_addr;
  logic [31:0]  rem_word;
  logic [623:0] syn_o;
  logic [31:0]  mem [16];
  logic [12:0]  exp_s [48];
  int n_chk, n_bad;

  bch_syn_expand dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_sel(cap_sel),
    .rem_addr(rem_addr), .rem_word(rem_word), .busy(busy), .done(done),
    .syn_o(syn_o)
  );

  always_comb rem_word = mem[rem_addr];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [12:0] ref_mul(logic [12:0] a, logic [12:0] b);
    logic [24:0] p;
    p = '0;
    for (int i = 0; i < 13; i++) if (b[i]) p = p ^ (25'(a) << i);
    for (int k = 24; k >= 13; k--) if (p[k]) p = p ^ (25'(POLYF) << (k - 13));
    return p[12:0];
  endfunction

  function automatic logic [12:0] ref_pow(int e);
    logic [12:0] r, b;
    r = 13'd1; b = 13'd2;
    while (e > 0) begin
      if (e % 2 == 1) r = ref_mul(r, b);
      b = ref_mul(b, b);
      e = e / 2;
    end
    return r;
  endfunction

  function automatic int ref_t(logic [2:0] code);
    case (code)
      3'd0: return 2;
      3'd1: return 4;
      3'd2: return 8;
      3'd3: return 12;
      default: return 24;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compute_exp(int t);
    for (int k = 0; k < 48; k++) exp_s[k] = '0;
    for (int i = 0; i < t; i++) begin
      logic [31:0] w;
      logic [12:0] r, s;
      w = mem[i / 2];
      r = (i % 2 == 1) ? w[28:16] : w[12:0];
      s = '0;
      for (int b = 0; b < 13; b++)
        if (r[b]) s = s ^ ref_pow(((2 * i + 1) * b) % 8191);
      exp_s[2 * i] = s;
    end
    for (int j = 1; j <= t; j++) exp_s[2 * j - 1] = ref_mul(exp_s[j - 1], exp_s[j - 1]);
  endtask

  task automatic compare(int lo, int hi, bit odd, bit even, string req);
    int bad, fa, fe;
    bad = 0; fa = 0; fe = 0;
    for (int k = lo; k <= hi; k++) begin
      bit sel;
      sel = (k % 2 == 1) ? odd : even;
      if (sel && syn_o[13 * (k - 1) +: 13] !== exp_s[k - 1]) begin
        if (bad == 0) begin
          fa = int'(syn_o[13 * (k - 1) +: 13]);
          fe = int'(exp_s[k - 1]);
        end
        bad++;
      end
    end
    check(bad == 0, req, fa, fe);
  endtask

  task automatic run(logic [2:0] code, bit poke, string tag);
    int t, cnt;
    bit seen;
    t = ref_t(code);
    compute_exp(t);
    @(negedge clk);
    start = 1'b1; cap_sel = code;
    cnt = 0; seen = 1'b0;
    while (!seen && cnt < 2000) begin
      @(negedge clk);
      start = 1'b0;
      cnt++;
      if (cnt == 1) check(busy, {"R7 busy after accept ", tag}, int'(busy), 1);
      if (poke && cnt == 5) begin
        start = 1'b1;
        cap_sel = 3'd0;
      end
      if (done) seen = 1'b1;
    end
    check(seen && cnt == 14 * t + 1, poke ? {"R8 latency with busy start ", tag}
          : {"R7 latency ", tag}, cnt, 14 * t + 1);
    compare(1, 2 * t, 1'b1, 1'b0, {"R3 odd syndromes ", tag});
    compare(1, 2 * t, 1'b0, 1'b1, {"R4 even syndromes ", tag});
    if (t < 24) compare(2 * t + 1, 48, 1'b1, 1'b1, {"R6 unused syndromes zero ", tag});
    @(negedge clk);
    check(!done && !busy, {"R7 done one cycle ", tag}, int'(done), 0);
  endtask

  task automatic fill_random(bit junk);
    for (int a = 0; a < 16; a++) begin
      mem[a] = $urandom();
      if (!junk) mem[a] = mem[a] & 32'h1FFF_1FFF;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start = 1'b0; cap_sel = 3'd0;
    for (int a = 0; a < 16; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    check(!done && !busy, "R1 idle flags in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !busy, "R1 idle flags after reset", int'(done), 0);
    check(syn_o == '0, "R1 syndromes zero after reset", int'(syn_o[12:0]), 0);

    // all-zero remainders give all-zero syndromes
    run(3'd0, 1'b0, "zero");

    // R9: remainder 0 = 1 gives S(1)=1 in the low field of syn_o
    mem[0] = 32'h0000_0001;
    run(3'd0, 1'b0, "unit");
    check(syn_o[12:0] == 13'd1, "R9 S1 in low bits", int'(syn_o[12:0]), 1);
    check(syn_o[25:13] == 13'd1, "R9 S2 in second field", int'(syn_o[25:13]), 1);

    // R2: single high bit in odd half, junk in ignored bits
    mem[0] = 32'hE000_E000 | 32'h1000_0000 | 32'h0000_0002;
    mem[1] = 32'hFFFF_E000;
    run(3'd1, 1'b0, "R2 packing");

    // R5: every capability code with random words incl. ignored-bit junk
    for (int c = 0; c < 8; c++) begin
      fill_random(1'b1);
      run(3'(c), 1'b0, $sformatf("R5 code%0d", c));
    end

    // R6: full run then small run, leftovers must be cleared
    fill_random(1'b0);
    run(3'd4, 1'b0, "R6 full");
    fill_random(1'b1);
    run(3'd0, 1'b0, "R6 small after full");

    // R8: start pulse inside a run is ignored
    fill_random(1'b1);
    run(3'd2, 1'b1, "R8 poke");
    fill_random(1'b0);
    run(3'd3, 1'b1, "R8 poke12");

    // R7: results hold while idle
    begin
      logic [623:0] snap;
      snap = syn_o;
      for (int a = 0; a < 16; a++) mem[a] = ~mem[a];
      repeat (5) @(negedge clk);
      check(syn_o == snap, "R7 hold while idle", int'(syn_o[12:0]), int'(snap[12:0]));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule